// File: doc/BRIEF.md
# Loader Entry and Serial Rate Detector

This block decides, after power-up, whether the processor core runs its application or enters a program-loading mode. When power-on reset is released, it holds the core in reset for a fixed number of oscillator clocks. At the end of that delay it samples two pins: the active-high reset pin and the active-low program-store-enable pin. If the reset pin is high and the enable pin is low at the same time, the block starts listening for a loader request. Otherwise it reports normal run, and the core reset follows the reset pin from then on.

While listening, the block waits for one of two events. The first is a parallel programming strobe. The second is a carriage-return character (0x0D) arriving on the serial receive line. Several candidate bit rates are watched at once, and each has its own 16x-oversampling receiver. Only the character value is recognised. No bit width is ever measured. The receiver that first frames a clean 0x0D selects the rate, and the block latches that rate's index and its 16x clock divisor for the serial loader that follows. Serial detection runs only while both strap bits on port 2 read high. With any other strap value, only the parallel strobe is accepted.

Candidate index 0 is the fastest rate. Its 16x divisor is `BASE_DIV`, and indices 1, 2 and 3 run 4, 8 and 32 times slower. These correspond to 9600, 2400, 1200 and 300 bps.

Top module: `ldr_entry`

## Requirements
- R1: After `por_n` is released, `core_reset` stays 1 and `run_normal`, `serial_mode` and `parallel_mode` stay 0 for the first POR_CYCLES-1 rising clock edges. The mode decision takes effect at edge POR_CYCLES.
- R2: If `rst_pin`=0 or `psen_n`=1 at the decision edge, `run_normal` becomes 1. From then on `core_reset` equals `rst_pin`.
- R3: If `rst_pin`=1 and `psen_n`=0 at the decision edge, the block listens. While it listens, `core_reset`=1 and all three mode outputs are 0.
- R4: While listening with `p2_hi`=2'b11, a serial frame is recognised at candidate rate i. The frame is a low start bit, then 8 data bits LSB first equal to 0x0D, then a high stop bit. On recognition, `serial_mode` becomes 1, `rate_sel`=i and `baud_div`=BASE_DIV·{1,4,8,32}[i].
- R5: A frame whose byte is not 0x0D, or whose stop bit is low, is discarded: `serial_mode` stays 0. A later correct 0x0D is still detected.
- R6: While listening, `prog_n` held low (two-stage synchronised) sets `parallel_mode`. This happens whatever the strap value is.
- R7: While listening with `p2_hi`≠2'b11, a serial 0x0D is ignored, and `serial_mode` stays 0.
- R8: At most one of `run_normal`, `serial_mode` and `parallel_mode` is 1. Once a load mode is set, it and `baud_div` hold until `por_n` falls, and later serial or strobe activity changes nothing.
- R9: In normal run, raising `rst_pin` while `psen_n`=0 returns the block to listening: `run_normal` falls and `core_reset` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high |
| psen_n | input | 1 | Program-store-enable pin, active low |
| p2_hi | input | 2 | Strap bits; both high select serial loading |
| prog_n | input | 1 | Parallel programming strobe, active low |
| rxd | input | 1 | Serial receive line, idle high |
| core_reset | output | 1 | Reset to the processor core |
| run_normal | output | 1 | Normal application run |
| serial_mode | output | 1 | Serial loader selected |
| parallel_mode | output | 1 | Parallel loader selected |
| rate_sel | output | SELW | Index of the matched candidate rate |
| baud_div | output | DIVW | 16x clock divisor of the matched rate |

## Verification
The hardest situation to reach is a rejected frame followed by a good one at the same rate, because the receivers for the other rates see the same line and must not take the garbage as a carriage return. The bench reaches it in two steps. It first sends 0x0D with a low stop bit and a 0xFF byte at one rate. It then checks that no mode was chosen before it sends a clean 0x0D. For every candidate rate in turn, it checks that the rate index and divisor select that rate and no neighbour.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam logic [7:0] CR_CODE = 8'h0D;

  typedef enum logic [2:0] {
    ST_POR, ST_RUN, ST_LISTEN, ST_SERIAL, ST_PARALLEL
  } ldr_state_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_e;

  // slowdown of candidate idx relative to the fastest one
  function automatic int rate_mult(input int idx);
    case (idx)
      0:       return 1;
      1:       return 4;
      2:       return 8;
      default: return 32;
    endcase
  endfunction

  function automatic int rate_div(input int base, input int idx);
    return base * rate_mult(idx);
  endfunction
endpackage

// File: rtl/ldr_por_timer.sv
module ldr_por_timer #(
  parameter int CYCLES = 21504
) (
  input  logic clk,
  input  logic por_n,
  output logic last
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      cnt <= '0;
    else if (cnt != CW'(CYCLES))     cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(CYCLES - 1));
endmodule

// File: rtl/ldr_cr_rx.sv
module ldr_cr_rx
  import ldr_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic en,
  input  logic rxd,
  output logic hit,
  output logic bad
);
  localparam int PW = $clog2(DIV + 1);
  logic [PW-1:0] pre;
  logic [3:0]    sub;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  rx_state_e     st;
  logic          tick;

  assign tick = (pre == PW'(DIV - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre <= '0; sub <= '0; bitn <= '0; sh <= '0;
      st <= RX_IDLE; hit <= 1'b0; bad <= 1'b0;
    end else if (!en) begin
      pre <= '0; sub <= '0; bitn <= '0;
      st <= RX_IDLE; hit <= 1'b0; bad <= 1'b0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      hit <= 1'b0;
      bad <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!rxd) begin st <= RX_START; sub <= '0; end
          RX_START: begin
            sub <= sub + 1'b1;
            if (sub == 4'd7) begin
              sub <= '0; bitn <= '0;
              st  <= rxd ? RX_IDLE : RX_DATA;
            end
          end
          RX_DATA: begin
            sub <= sub + 1'b1;
            if (sub == 4'd15) begin
              sh <= {rxd, sh[7:1]};
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) st <= RX_STOP;
            end
          end
          default: begin
            sub <= sub + 1'b1;
            if (sub == 4'd15) begin
              hit <= rxd && (sh == CR_CODE);
              bad <= !(rxd && (sh == CR_CODE));
              st  <= RX_IDLE;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ldr_entry.sv
module ldr_entry
  import ldr_pkg::*;
#(
  parameter int POR_CYCLES = 21504,
  parameter int BASE_DIV   = 6,
  parameter int NUM_RATES  = 4,
  localparam int SELW = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1,
  localparam int DIVW = $clog2(BASE_DIV * 32 + 1)
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_pin,
  input  logic            psen_n,
  input  logic [1:0]      p2_hi,
  input  logic            prog_n,
  input  logic            rxd,
  output logic            core_reset,
  output logic            run_normal,
  output logic            serial_mode,
  output logic            parallel_mode,
  output logic [SELW-1:0] rate_sel,
  output logic [DIVW-1:0] baud_div
);
  ldr_state_e          state;
  logic                tmr_last;
  logic [1:0]          rxd_q, prog_q;
  logic [NUM_RATES-1:0] hits, bads;
  logic                rx_en, p2_ok, strobe_seen, cr_win, load_req;
  logic                listening, por_busy;
  logic [SELW-1:0]     win_idx;
  logic [DIVW-1:0]     win_div;

  ldr_por_timer #(.CYCLES(POR_CYCLES)) u_tmr (
    .clk(clk), .por_n(por_n), .last(tmr_last)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rxd_q  <= 2'b11;
      prog_q <= 2'b11;
    end else begin
      rxd_q  <= {rxd_q[0], rxd};
      prog_q <= {prog_q[0], prog_n};
    end
  end

  assign p2_ok       = &p2_hi;
  assign strobe_seen = !prog_q[1];
  assign load_req    = rst_pin && !psen_n;
  assign listening   = (state == ST_LISTEN);
  assign por_busy    = (state == ST_POR);
  assign rx_en       = listening && p2_ok;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rx
    ldr_cr_rx #(.DIV(rate_div(BASE_DIV, g))) u_rx (
      .clk(clk), .por_n(por_n), .en(rx_en), .rxd(rxd_q[1]),
      .hit(hits[g]), .bad(bads[g])
    );
  end

  // lowest index (fastest rate) wins a tie
  always_comb begin
    cr_win  = 1'b0;
    win_idx = '0;
    win_div = '0;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (hits[i]) begin
        cr_win  = 1'b1;
        win_idx = SELW'(i);
        win_div = DIVW'(rate_div(BASE_DIV, i));
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state    <= ST_POR;
      rate_sel <= '0;
      baud_div <= '0;
    end else begin
      case (state)
        ST_POR:    if (tmr_last) state <= load_req ? ST_LISTEN : ST_RUN;
        ST_RUN:    if (load_req) state <= ST_LISTEN;
        ST_LISTEN: begin
          if (strobe_seen) state <= ST_PARALLEL;
          else if (cr_win && p2_ok) begin
            state    <= ST_SERIAL;
            rate_sel <= win_idx;
            baud_div <= win_div;
          end
        end
        default: state <= state;
      endcase
    end
  end

  assign core_reset    = (state == ST_RUN) ? rst_pin : 1'b1;
  assign run_normal    = (state == ST_RUN);
  assign serial_mode   = (state == ST_SERIAL);
  assign parallel_mode = (state == ST_PARALLEL);
endmodule

// File: rtl/ldr_entry_chk.sv
module ldr_entry_chk #(
  parameter int DIVW = 8
) (
  input logic            clk,
  input logic            por_n,
  input logic            core_reset,
  input logic            run_normal,
  input logic            serial_mode,
  input logic            parallel_mode,
  input logic            listening,
  input logic            por_busy,
  input logic            p2_ok,
  input logic            cr_win,
  input logic            strobe_seen,
  input logic [DIVW-1:0] baud_div
);
  // R1
  delay_holds_core_chk: assert property (@(posedge clk) disable iff (!por_n)
    por_busy |-> core_reset && !run_normal && !serial_mode && !parallel_mode);

  // R3
  listen_holds_core_chk: assert property (@(posedge clk) disable iff (!por_n)
    listening |-> core_reset && !run_normal);

  // R4
  cr_selects_serial_chk: assert property (@(posedge clk) disable iff (!por_n)
    listening && cr_win && p2_ok && !strobe_seen |=> serial_mode);

  // R6
  strobe_selects_parallel_chk: assert property (@(posedge clk) disable iff (!por_n)
    listening && strobe_seen |=> parallel_mode);

  // R7
  strap_blocks_serial_chk: assert property (@(posedge clk) disable iff (!por_n)
    listening && !p2_ok |=> !serial_mode);

  // R8
  modes_exclusive_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({run_normal, serial_mode, parallel_mode}));

  // R8
  serial_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    serial_mode |=> serial_mode && $stable(baud_div));

  // R8
  parallel_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    parallel_mode |=> parallel_mode);
endmodule

bind ldr_entry ldr_entry_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .por_n(por_n), .core_reset(core_reset),
  .run_normal(run_normal), .serial_mode(serial_mode),
  .parallel_mode(parallel_mode), .listening(listening),
  .por_busy(por_busy), .p2_ok(p2_ok), .cr_win(cr_win),
  .strobe_seen(strobe_seen), .baud_div(baud_div)
);

// File: tb/test_ldr_entry.sv
module test_ldr_entry;
  localparam int POR  = 64;
  localparam int BASE = 2;
  localparam int NR   = 4;
  localparam int SELW = 2;
  localparam int DIVW = $clog2(BASE * 32 + 1);
  localparam int SLOW [4] = '{1, 4, 8, 32};

  logic clk = 0, por_n = 0, rst_pin = 0, psen_n = 1, prog_n = 1, rxd = 1;
  logic [1:0] p2_hi = 2'b11;
  logic core_reset, run_normal, serial_mode, parallel_mode;
  logic [SELW-1:0] rate_sel;
  logic [DIVW-1:0] baud_div;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ldr_entry #(.POR_CYCLES(POR), .BASE_DIV(BASE), .NUM_RATES(NR)) i_ldr_entry (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .psen_n(psen_n),
    .p2_hi(p2_hi), .prog_n(prog_n), .rxd(rxd), .core_reset(core_reset),
    .run_normal(run_normal), .serial_mode(serial_mode),
    .parallel_mode(parallel_mode), .rate_sel(rate_sel), .baud_div(baud_div)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int modes();
    return {29'd0, run_normal, serial_mode, parallel_mode};
  endfunction

  task automatic power_up(input logic r, input logic ps, input logic [1:0] p2);
    @(negedge clk);
    por_n = 0; rst_pin = r; psen_n = ps; p2_hi = p2; prog_n = 1; rxd = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset core", core_reset, 1);
    chk("R1 reset modes", modes(), 0);
    por_n = 1;
    repeat (POR - 1) @(negedge clk);
    chk("R1 still held", core_reset, 1);
    chk("R1 no mode yet", modes(), 0);
    @(negedge clk);
  endtask

  task automatic send(input int ri, input logic [7:0] b, input logic stopv);
    int bt = BASE * SLOW[ri] * 16;
    rxd = 0; repeat (bt) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxd = b[k]; repeat (bt) @(negedge clk);
    end
    rxd = stopv; repeat (bt) @(negedge clk);
    rxd = 1; repeat (2 * bt) @(negedge clk);
  endtask

  task automatic t_run();
    power_up(1'b0, 1'b0, 2'b11);
    chk("R2 run flag", run_normal, 1);
    chk("R2 core free", core_reset, 0);
    rst_pin = 1; #1;
    chk("R2 core follows pin", core_reset, 1);
    power_up(1'b1, 1'b1, 2'b11);
    chk("R2 psen high runs", run_normal, 1);
    chk("R2 core follows pin high", core_reset, 1);
  endtask

  task automatic t_serial(input int ri, input bit with_junk);
    power_up(1'b1, 1'b0, 2'b11);
    chk("R3 listening core", core_reset, 1);
    chk("R3 listening modes", modes(), 0);
    if (with_junk) begin
      send(ri, 8'h0D, 1'b0);
      chk("R5 bad stop discarded", serial_mode, 0);
      send(ri, 8'hFF, 1'b1);
      chk("R5 wrong byte discarded", serial_mode, 0);
    end
    send(ri, 8'h0D, 1'b1);
    chk("R4 serial set", serial_mode, 1);
    chk("R4 rate index", rate_sel, ri);
    chk("R4 divisor", baud_div, BASE * SLOW[ri]);
    prog_n = 0; repeat (5) @(negedge clk); prog_n = 1;
    chk("R8 strobe after serial", modes(), 3'b010);
  endtask

  task automatic t_parallel();
    power_up(1'b1, 1'b0, 2'b11);
    prog_n = 0; repeat (4) @(negedge clk); prog_n = 1;
    chk("R6 parallel set", modes(), 3'b001);
    send(0, 8'h0D, 1'b1);
    chk("R8 CR after parallel", modes(), 3'b001);
  endtask

  task automatic t_strap();
    power_up(1'b1, 1'b0, 2'b10);
    send(0, 8'h0D, 1'b1);
    chk("R7 CR ignored", modes(), 0);
    chk("R7 core held", core_reset, 1);
    prog_n = 0; repeat (4) @(negedge clk); prog_n = 1;
    chk("R6 parallel any strap", modes(), 3'b001);
  endtask

  task automatic t_reenter();
    power_up(1'b0, 1'b0, 2'b11);
    chk("R9 starts running", run_normal, 1);
    rst_pin = 1; repeat (2) @(negedge clk);
    chk("R9 run dropped", run_normal, 0);
    chk("R9 core held", core_reset, 1);
    send(2, 8'h0D, 1'b1);
    chk("R9 serial from run", serial_mode, 1);
    chk("R9 rate index", rate_sel, 2);
  endtask

  initial begin
    t_run();
    t_serial(0, 1'b0);
    t_serial(1, 1'b1);
    t_serial(2, 1'b0);
    t_serial(3, 1'b0);
    t_parallel();
    t_strap();
    t_reenter();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule